// File: doc/BRIEF.md
# Video Decoder Status Register

This block presents an 8-bit status word for a video decoder on a plain register read port. Most of the word is live: horizontal lock, detected line format, field parity and PLL unlock flow straight from their producers to the read value. Two bits are sticky. Luma and chroma converter overflow pulses set flags that stay at 1 until software writes the register or the chip is reset.

A small presence detector sits inside the block. It counts line periods that end without an input sync. After a run of 31 such periods, the video-present bit drops to 0. The first line period that does carry a sync raises the bit again and restarts the count. Software reads `rd_data` at any time, and a one-cycle `wr_en` pulse clears the overflow flags. The write data is not used.

Top module: `vdec_status`

## Requirements
- R1: After a synchronous reset, with all live inputs low, `rd_data` reads 0x00. The video-present bit is 0 after reset.
- R2: The live bits follow their inputs in the same cycle. Bit 2 is 1 while the PLL is unlocked. Bit 4 is 1 for the 625-line format. Bit 5 is 1 for an even field and 0 for an odd field. Bit 6 is 1 while in horizontal lock.
- R3: A chroma overflow pulse sets bit 0 and a luma overflow pulse sets bit 1, from the cycle after the pulse. Each bit then holds at 1 without further pulses.
- R4: A cycle with `wr_en` high clears both overflow bits from the next cycle. If an overflow pulse arrives in the same cycle as the write, that bit reads 1 afterwards.
- R5: Bit 3 always reads 0.
- R6: Bit 7 drops to 0 after exactly 31 consecutive line periods without sync, counting only cycles with `line_tick` high. It stays 1 after 30.
- R7: A line period with sync sets bit 7 to 1 from the next cycle and restarts the miss count. A later drop therefore needs another full run of 31 sync-less lines.
- R8: Cycles without `line_tick` neither advance nor reset the miss count, whatever `sync_seen` holds.
- R9: A write does not change bit 7 or any live bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe at the end of each line period |
| sync_seen | input | 1 | A sync was found in the line ending with `line_tick` |
| field_even | input | 1 | Current field parity, 1 = even |
| hlock_in | input | 1 | Horizontal lock result |
| fmt625_in | input | 1 | Line format result, 1 = 625 lines |
| pll_unlock_in | input | 1 | PLL out of lock |
| luma_ovf | input | 1 | Luma converter overflow pulse |
| chroma_ovf | input | 1 | Chroma converter overflow pulse |
| wr_en | input | 1 | Register write strobe |
| rd_data | output | 8 | Status word |

## Verification
The presence detector is driven with directed runs of exactly 30 and 31 sync-less lines, which separates a correct limit from an off-by-one. A run broken by a synced line at line 20 shows whether the count restarts or only pauses. A mixed pattern of idle cycles, some with `sync_seen` high and no tick, confirms that only ticked cycles count. Random stimulus toggles the live inputs and fires overflow pulses and writes in all four combinations, including a pulse in the same cycle as a write, which shows whether set has priority over clear.

// File: rtl/vdec_status_pkg.sv
// Package: bit positions of the status word and detector sizing shared by
// the status register, its sub-blocks and its checker.
package vdec_status_pkg;
    localparam int STAT_W      = 8;
    localparam int BIT_COVF    = 0;
    localparam int BIT_LOVF    = 1;
    localparam int BIT_PLL     = 2;
    localparam int BIT_RSVD    = 3;
    localparam int BIT_FMT     = 4;
    localparam int BIT_FIELD   = 5;
    localparam int BIT_HLOCK   = 6;
    localparam int BIT_PRESENT = 7;
    localparam int NUM_STICKY  = 2;
    localparam int DEF_MISS_LIMIT = 31;
endpackage

// File: rtl/vdec_presence.sv
// Presence detector: counts line periods that end without sync. The present
// flag clears once MISS_LIMIT such periods occur in a row, and sets again on
// the first synced period, which also restarts the count.
// Assumes line_tick is a one-cycle strobe and sync_seen is valid with it.
module vdec_presence #(
    parameter int MISS_LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic sync_seen,
    output logic present
);
    localparam int CNT_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(MISS_LIMIT);

    logic [CNT_W-1:0] miss_cnt;
    logic             at_limit;
    logic [CNT_W-1:0] cnt_inc;

    // Saturating increment of the miss count.
    always_comb begin
        at_limit = (miss_cnt == LIMIT_V);
        cnt_inc  = at_limit ? miss_cnt : miss_cnt + CNT_W'(1);
    end

    // Count missed lines and update the present flag on each line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_cnt <= '0;
            present  <= 1'b0;
        end else if (line_tick) begin
            if (sync_seen) begin
                miss_cnt <= '0;
                present  <= 1'b1;
            end else begin
                miss_cnt <= cnt_inc;
                if (cnt_inc == LIMIT_V) present <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vdec_sticky.sv
// Sticky flag bank: each flag sets on its event pulse and clears on a
// write strobe. A set in the same cycle as a clear wins.
// Assumes event pulses are synchronous to clk.
module vdec_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_o[g] <= 1'b0;
            else if (set_i[g])   flag_o[g] <= 1'b1;
            else if (clr_i)      flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/vdec_status.sv
// Video decoder status register: assembles live status inputs, sticky
// overflow flags and a derived video-present bit into one read word.
// Assumes all inputs are synchronous to clk. The write data is not used,
// because a write only clears the sticky flags.
module vdec_status
    import vdec_status_pkg::*;
#(
    parameter int MISS_LIMIT = DEF_MISS_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              sync_seen,
    input  logic              field_even,
    input  logic              hlock_in,
    input  logic              fmt625_in,
    input  logic              pll_unlock_in,
    input  logic              luma_ovf,
    input  logic              chroma_ovf,
    input  logic              wr_en,
    output logic [STAT_W-1:0] rd_data
);
    logic                  present;
    logic [NUM_STICKY-1:0] ovf_set;
    logic [NUM_STICKY-1:0] ovf_flag;

    assign ovf_set = {luma_ovf, chroma_ovf};

    vdec_presence #(.MISS_LIMIT(MISS_LIMIT)) u_presence (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .sync_seen (sync_seen),
        .present   (present)
    );

    vdec_sticky #(.N(NUM_STICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .clr_i  (wr_en),
        .flag_o (ovf_flag)
    );

    // Assemble the read word from held and live sources.
    always_comb begin
        rd_data              = '0;
        rd_data[BIT_COVF]    = ovf_flag[0];
        rd_data[BIT_LOVF]    = ovf_flag[1];
        rd_data[BIT_PLL]     = pll_unlock_in;
        rd_data[BIT_RSVD]    = 1'b0;
        rd_data[BIT_FMT]     = fmt625_in;
        rd_data[BIT_FIELD]   = field_even;
        rd_data[BIT_HLOCK]   = hlock_in;
        rd_data[BIT_PRESENT] = present;
    end
endmodule

// File: rtl/vdec_status_chk.sv
// Checker for vdec_status: relates the ports across cycles. It is attached
// to every instance through the bind statement below.
module vdec_status_chk
    import vdec_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              sync_seen,
    input logic              field_even,
    input logic              hlock_in,
    input logic              luma_ovf,
    input logic              chroma_ovf,
    input logic              wr_en,
    input logic [STAT_W-1:0] rd_data
);
    p_live_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_FIELD] == field_even && rd_data[BIT_HLOCK] == hlock_in);
    p_luma_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        luma_ovf |=> rd_data[BIT_LOVF]);
    p_chroma_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_ovf |=> rd_data[BIT_COVF]);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_data[BIT_LOVF]) |=> rd_data[BIT_LOVF]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !luma_ovf && !chroma_ovf) |=> (rd_data[1:0] == 2'b00));
    p_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_RSVD] == 1'b0);
    p_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && sync_seen) |=> rd_data[BIT_PRESENT]);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(rd_data[BIT_PRESENT]));
endmodule

bind vdec_status vdec_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .sync_seen  (sync_seen),
    .field_even (field_even),
    .hlock_in   (hlock_in),
    .luma_ovf   (luma_ovf),
    .chroma_ovf (chroma_ovf),
    .wr_en      (wr_en),
    .rd_data    (rd_data)
);

// File: tb/sim_vdec_status.sv
// Bench for vdec_status: directed presence runs plus seeded random traffic,
// compared against a model kept in bench variables.
module sim_vdec_status;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 0, sync_seen = 0, field_even = 0, hlock_in = 0;
    logic fmt625_in = 0, pll_unlock_in = 0, luma_ovf = 0, chroma_ovf = 0, wr_en = 0;
    logic [7:0] rd_data;

    int n_chk = 0, n_bad = 0;
    bit m_pres = 0, m_l = 0, m_c = 0;
    int m_miss = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdec_status u0 (.*);

    function automatic logic [7:0] expect_word();
        return {m_pres, hlock_in, field_even, fmt625_in, 1'b0, pll_unlock_in, m_l, m_c};
    endfunction

    task automatic check(string req, logic [7:0] mask);
        logic [7:0] e;
        e = expect_word();
        n_chk++;
        if ((rd_data & mask) !== (e & mask)) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h (mask %02h)", req, rd_data, e, mask);
        end
    endtask

    // One clock: inputs are already driven, update model at edge, check after.
    task automatic step(string req, logic [7:0] mask);
        @(posedge clk);
        if (rst_n) begin
            if (luma_ovf) m_l = 1; else if (wr_en) m_l = 0;
            if (chroma_ovf) m_c = 1; else if (wr_en) m_c = 0;
            if (line_tick) begin
                if (sync_seen) begin m_pres = 1; m_miss = 0; end
                else begin
                    if (m_miss < LIMIT) m_miss++;
                    if (m_miss == LIMIT) m_pres = 0;
                end
            end
        end
        #1;
        check(req, mask);
        @(negedge clk);
        {line_tick, sync_seen, luma_ovf, chroma_ovf, wr_en} = '0;
    endtask

    task automatic lines(int n, bit s, string req, logic [7:0] mask);
        for (int i = 0; i < n; i++) begin
            line_tick = 1; sync_seen = s;
            step(req, mask);
            step(req, mask);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1; check("R1 reset word", 8'hFF);
        // R2 live bits, same cycle
        @(negedge clk);
        pll_unlock_in = 1; #1; check("R2 pll bit2", 8'h04);
        fmt625_in = 1; #1; check("R2 format bit4", 8'h10);
        field_even = 1; #1; check("R2 field bit5", 8'h20);
        hlock_in = 1; #1; check("R2 hlock bit6", 8'h40);
        // R7 first synced line raises present
        lines(1, 1, "R7 present rises", 8'h80);
        // R6 30 misses keep present, the 31st drops it
        lines(30, 0, "R6 30 misses keep present", 8'h80);
        lines(1, 0, "R6 31st miss drops present", 8'h80);
        // R7 resync then restart: 20 misses, sync, 30 misses still present
        lines(1, 1, "R7 resync", 8'h80);
        lines(20, 0, "R7 partial run", 8'h80);
        lines(1, 1, "R7 restart", 8'h80);
        lines(30, 0, "R7 count restarted", 8'h80);
        // R8 idle cycles with sync_seen high do not reset the count
        for (int i = 0; i < 5; i++) begin sync_seen = 1; step("R8 no tick", 8'h80); end
        lines(1, 0, "R8 31st counted miss", 8'h80);
        // R3/R4 directed
        lines(1, 1, "R7 back present", 8'h80);
        luma_ovf = 1; step("R3 luma set", 8'h03);
        step("R3 luma holds", 8'h03);
        chroma_ovf = 1; step("R3 chroma set", 8'h03);
        wr_en = 1; step("R4 write clears", 8'h03);
        luma_ovf = 1; step("R4 set", 8'h03);
        wr_en = 1; luma_ovf = 1; step("R4 set wins", 8'h03);
        wr_en = 1; step("R9 write keeps live and present", 8'hFC);
        // Random traffic, full-word compare
        for (int i = 0; i < 3000; i++) begin
            line_tick = ($urandom_range(0, 3) == 0);
            sync_seen = ($urandom_range(0, 15) == 0);
            luma_ovf = ($urandom_range(0, 9) == 0);
            chroma_ovf = ($urandom_range(0, 9) == 0);
            wr_en = ($urandom_range(0, 7) == 0);
            field_even = 1'($urandom);
            hlock_in = 1'($urandom);
            fmt625_in = 1'($urandom);
            pll_unlock_in = 1'($urandom);
            #1;
            step("R2 R3 R4 R5 R6 R9 random", 8'hFF);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule